// File: doc/BRIEF.md
# Timer Output Compare Channel Bank

This block is a free-running 16-bit up-counter with a power-of-two prescaler. A set of output-compare channels watches it. Each channel holds a compare value. When the counter steps onto that value, the channel can drive its output pin high, drive it low, toggle it, or leave it alone. It also records the event in a status flag. A level interrupt is raised while any flagged channel has its interrupt enabled.

Software uses a small synchronous register port to set up the channels, read the counter and pins, and clear flags. Clearing a flag takes a write of one to its bit. To make a pulse-width signal, the handler adds the high or low time to a channel's compare value on each match and swaps the action between set and clear.

Top module: `tmr_oc_bank`

## Requirements
- R1: The counter resets to 0. It advances only while the run bit (bit 0 of the control register at address 0) is 1, and it holds its value while that bit is 0.
- R2: Control bits [3:1] hold an exponent k. The counter advances once every 2^k clock cycles, so k = 0 advances it on every cycle.
- R3: A channel whose bit in the mode register (address 1) is 0 never changes its pin and never sets its flag.
- R4: The action field for channel i is bits [2i+1:2i] of the action register (address 2). On a match, code 11 drives the pin to 1, code 10 drives it to 0, and code 01 inverts it. The pin changes on the same clock edge that moves the counter onto the compare value. Pins reset to 0.
- R5: A match occurs when an enabled channel's compare register (address 8+i) equals the value the counter is stepping onto. The match sets flag bit i on that same edge.
- R6: A write to the flag register (address 4) clears each flag whose data bit is 1 and leaves flags whose data bit is 0 unchanged. A match in the same cycle keeps its flag set.
- R7: The irq output is 1 exactly while some channel has both its flag and its bit in the interrupt-enable register (address 3) set.
- R8: The counter wraps from 0xFFFF to 0x0000. A compare value of 0 matches on the step that wraps the counter.
- R9: Action code 00 on an enabled channel leaves the pin unchanged on a match, but the match still sets the flag.
- R10: Reads are combinational. Addresses 0 to 3 and 8+i return the stored values. Address 4 returns the flags, address 5 the counter, address 6 the pins, and any other address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| oc_pin | output | 4 | Compare output pins, one per channel |
| irq | output | 1 | Level interrupt request |

## Verification
The hardest condition to reach is the wrap: a compare at 0xFFFF and a compare at 0 firing on two consecutive counter steps. To get there, the bench lets the counter run through its full 65536-value range at divide-by-one. It polls the flags every cycle so the step before the wrap and the step onto 0 are caught in adjacent cycles. A pulse-width sequence driven by a handler model also places each new compare value only a few tens of cycles ahead of the counter. That checks the set/clear swap under the same timing a real handler would face.

// File: rtl/tmr_oc_pkg.sv
// Shared definitions for the output-compare timer: match action codes and
// register addresses. Assumes a 4-bit register address space.
package tmr_oc_pkg;
    typedef enum logic [1:0] {
        ACT_NONE   = 2'b00,
        ACT_TOGGLE = 2'b01,
        ACT_LOW    = 2'b10,
        ACT_HIGH   = 2'b11
    } oc_act_e;

    localparam int ADDR_W = 4;
    localparam logic [ADDR_W-1:0] A_CTRL = 4'd0;
    localparam logic [ADDR_W-1:0] A_MODE = 4'd1;
    localparam logic [ADDR_W-1:0] A_ACT  = 4'd2;
    localparam logic [ADDR_W-1:0] A_IE   = 4'd3;
    localparam logic [ADDR_W-1:0] A_FLAG = 4'd4;
    localparam logic [ADDR_W-1:0] A_CNT  = 4'd5;
    localparam logic [ADDR_W-1:0] A_PIN  = 4'd6;
    localparam int                A_CMP0 = 8;
endpackage

// File: rtl/tmr_prescale.sv
// Prescaled free-running counter. A PCW-bit divider runs while en_i is
// high; the counter steps when the low psc_i divider bits are all ones,
// i.e. once every 2^psc_i cycles. Assumes psc_i <= PCW.
module tmr_prescale #(
    parameter int CW  = 16,
    parameter int PSW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic [PSW-1:0] psc_i,
    output logic          tick_o,
    output logic [CW-1:0] cnt_o,
    output logic [CW-1:0] cnt_nxt_o
);
    localparam int PCW = (1 << PSW) - 1;

    logic [PCW-1:0] pre_q;
    logic [PCW-1:0] msk;
    logic [CW-1:0]  cnt_q;

    // Build the mask of divider bits that must all be one for a step.
    always_comb begin
        for (int b = 0; b < PCW; b++) msk[b] = (b < int'(psc_i));
    end

    assign tick_o    = en_i && ((pre_q & msk) == msk);
    assign cnt_nxt_o = cnt_q + 1'b1;
    assign cnt_o     = cnt_q;

    // Divider runs only while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)    pre_q <= '0;
        else if (en_i) pre_q <= pre_q + 1'b1;
    end

    // Counter steps on each prescaled tick, wrapping naturally.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (tick_o) cnt_q <= cnt_nxt_o;
    end

    a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> $stable(cnt_q));
    a_r2_div1: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && psc_i == '0) |=> cnt_q == $past(cnt_q) + 1'b1);
    a_r8_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && cnt_q == {CW{1'b1}}) |=> cnt_q == '0);
endmodule

// File: rtl/tmr_oc_chan.sv
// One output-compare channel: detects the counter stepping onto its
// compare value, applies the selected pin action and keeps a sticky
// flag cleared by clr_i. A match in the same cycle wins over a clear.
module tmr_oc_chan
    import tmr_oc_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic [CW-1:0] cnt_nxt_i,
    input  logic [CW-1:0] cmp_i,
    input  logic          mode_i,
    input  logic [1:0]    act_i,
    input  logic          clr_i,
    output logic          flag_o,
    output logic          pin_o
);
    logic    hit;
    logic    flag_q;
    logic    pin_q;
    oc_act_e act;

    assign act    = oc_act_e'(act_i);
    assign hit    = tick_i && mode_i && (cnt_nxt_i == cmp_i);
    assign flag_o = flag_q;
    assign pin_o  = pin_q;

    // Sticky match flag, set has priority over write-one clear.
    always_ff @(posedge clk) begin
        if (!rst_n)     flag_q <= 1'b0;
        else if (hit)   flag_q <= 1'b1;
        else if (clr_i) flag_q <= 1'b0;
    end

    // Apply the programmed action to the pin on a match.
    always_ff @(posedge clk) begin
        if (!rst_n) pin_q <= 1'b0;
        else if (hit) begin
            case (act)
                ACT_HIGH:   pin_q <= 1'b1;
                ACT_LOW:    pin_q <= 1'b0;
                ACT_TOGGLE: pin_q <= ~pin_q;
                default:    pin_q <= pin_q;
            endcase
        end
    end

    a_r5_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> flag_q);
    a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !hit) |=> !flag_q);
    a_r3_pin_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_i |=> $stable(pin_q));
    a_r4_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && act == ACT_TOGGLE) |=> pin_q != $past(pin_q));
    a_r9_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && act == ACT_NONE) |=> $stable(pin_q));
endmodule

// File: rtl/tmr_oc_bank.sv
// Top of the output-compare timer: register file, prescaled counter and
// NCH compare channels. Assumes NCH <= 8 and CW >= 2*NCH, CW >= PSW+1.
module tmr_oc_bank
    import tmr_oc_pkg::*;
#(
    parameter int NCH = 4,
    parameter int CW  = 16,
    parameter int PSW = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CW-1:0]     bus_wdata,
    output logic [CW-1:0]     bus_rdata,
    output logic [NCH-1:0]    oc_pin,
    output logic              irq
);
    localparam int AW = 2 * NCH;

    logic           run_q;
    logic [PSW-1:0] psc_q;
    logic [NCH-1:0] mode_q;
    logic [AW-1:0]  act_q;
    logic [NCH-1:0] ie_q;
    logic [CW-1:0]  cmp_q [NCH];
    logic           tick;
    logic [CW-1:0]  cnt;
    logic [CW-1:0]  cnt_nxt;
    logic [NCH-1:0] flag;
    logic [NCH-1:0] clr;

    // Configuration register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            psc_q  <= '0;
            mode_q <= '0;
            act_q  <= '0;
            ie_q   <= '0;
            for (int i = 0; i < NCH; i++) cmp_q[i] <= '0;
        end else if (bus_we) begin
            if (bus_addr == A_CTRL) begin
                run_q <= bus_wdata[0];
                psc_q <= bus_wdata[PSW:1];
            end
            if (bus_addr == A_MODE) mode_q <= bus_wdata[NCH-1:0];
            if (bus_addr == A_ACT)  act_q  <= bus_wdata[AW-1:0];
            if (bus_addr == A_IE)   ie_q   <= bus_wdata[NCH-1:0];
            for (int i = 0; i < NCH; i++)
                if (bus_addr == ADDR_W'(A_CMP0 + i)) cmp_q[i] <= bus_wdata;
        end
    end

    // Combinational read mux.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL:  bus_rdata = CW'({psc_q, run_q});
            A_MODE:  bus_rdata = CW'(mode_q);
            A_ACT:   bus_rdata = CW'(act_q);
            A_IE:    bus_rdata = CW'(ie_q);
            A_FLAG:  bus_rdata = CW'(flag);
            A_CNT:   bus_rdata = cnt;
            A_PIN:   bus_rdata = CW'(oc_pin);
            default: begin
                for (int i = 0; i < NCH; i++)
                    if (bus_addr == ADDR_W'(A_CMP0 + i)) bus_rdata = cmp_q[i];
            end
        endcase
    end

    tmr_prescale #(.CW(CW), .PSW(PSW)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (run_q),
        .psc_i     (psc_q),
        .tick_o    (tick),
        .cnt_o     (cnt),
        .cnt_nxt_o (cnt_nxt)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        assign clr[g] = bus_we && (bus_addr == A_FLAG) && bus_wdata[g];
        tmr_oc_chan #(.CW(CW)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick_i    (tick),
            .cnt_nxt_i (cnt_nxt),
            .cmp_i     (cmp_q[g]),
            .mode_i    (mode_q[g]),
            .act_i     (act_q[2*g+1:2*g]),
            .clr_i     (clr[g]),
            .flag_o    (flag[g]),
            .pin_o     (oc_pin[g])
        );
    end

    assign irq = |(flag & ie_q);

    a_r7_irq_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (ie_q == '0 && !(bus_we && bus_addr == A_IE)) |=> !irq);
endmodule

// File: tb/tmr_oc_bank_tb.sv
`timescale 1ns/1ps
module tmr_oc_bank_tb;
    localparam int NCH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [NCH-1:0] oc_pin;
    logic        irq;

    int vecs = 0;
    int errs = 0;
    bit done = 0;

    // reference model state
    int m_run, m_psc, m_mode, m_act, m_ie, m_flag, m_pin, m_cnt, m_pre;
    int m_cmp [NCH];
    int t_div, t_hit, t_a;
    bit t_tk;

    always #2.5 clk = ~clk;

    tmr_oc_bank #(.NCH(NCH)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .oc_pin(oc_pin), .irq(irq)
    );

    // behavioural reference, advanced on every rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = 0; m_psc = 0; m_mode = 0; m_act = 0; m_ie = 0;
            m_flag = 0; m_pin = 0; m_cnt = 0; m_pre = 0;
            for (int i = 0; i < NCH; i++) m_cmp[i] = 0;
        end else begin
            t_div = 1 << m_psc;
            t_tk = (m_run != 0) && ((m_pre % t_div) == t_div - 1);
            t_hit = 0;
            if (m_run != 0) m_pre = (m_pre + 1) % 128;
            if (t_tk) begin
                m_cnt = (m_cnt + 1) % 65536;
                for (int i = 0; i < NCH; i++) begin
                    if (((m_mode >> i) & 1) && m_cnt == m_cmp[i]) begin
                        t_hit |= 1 << i;
                        t_a = (m_act >> (2 * i)) & 3;
                        if (t_a == 3) m_pin |= 1 << i;
                        else if (t_a == 2) m_pin &= ~(1 << i);
                        else if (t_a == 1) m_pin ^= 1 << i;
                    end
                end
            end
            if (bus_we) begin
                case (int'(bus_addr))
                    0: begin m_run = bus_wdata & 1; m_psc = (bus_wdata >> 1) & 7; end
                    1: m_mode = bus_wdata & ((1 << NCH) - 1);
                    2: m_act = bus_wdata & ((1 << (2 * NCH)) - 1);
                    3: m_ie = bus_wdata & ((1 << NCH) - 1);
                    4: m_flag &= ~int'(bus_wdata);
                    default: if (bus_addr >= 8 && bus_addr < 8 + NCH) m_cmp[bus_addr - 8] = bus_wdata;
                endcase
            end
            m_flag |= t_hit;
        end
    end

    function automatic int m_read(int a);
        case (a)
            0: return m_run | (m_psc << 1);
            1: return m_mode;
            2: return m_act;
            3: return m_ie;
            4: return m_flag;
            5: return m_cnt;
            6: return m_pin;
            default: return (a >= 8 && a < 8 + NCH) ? m_cmp[a - 8] : 0;
        endcase
    endfunction

    task automatic chk(string req, int got, int exp);
        vecs++;
        if (got !== exp) begin
            errs++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    // per-cycle comparison of pins and interrupt against the model
    always @(negedge clk) begin
        if (rst_n && !done)
            chk("R4 R7 cycle compare", {oc_pin, irq},
                ((m_pin & 15) << 1) | ((m_flag & m_ie) != 0 ? 1 : 0));
    end

    task automatic wr(int a, int d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 4'(a); bus_wdata = 16'(d);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(int a, output int v);
        @(negedge clk);
        bus_addr = 4'(a);
        #1;
        v = int'(bus_rdata);
        chk("R10 readback", v, m_read(a));
    endtask

    task automatic wait_flag(int msk, int maxc, output bit ok);
        int v;
        ok = 0;
        for (int i = 0; i < maxc; i++) begin
            rd(4, v);
            if ((v & msk) != 0) begin ok = 1; return; end
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errs++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end

    initial begin
        int v, c0, c1, nxt;
        bit ok;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(5, v); chk("R1 reset count", v, 0);
        rd(6, v); chk("R4 reset pins", v, 0);
        rd(4, v); chk("R6 reset flags", v, 0);
        chk("R7 reset irq", irq, 0);

        // ch0 high, ch1 low, ch2 toggle, ch3 high but mode off
        wr(2, 'hDB); wr(1, 7);
        wr(8, 4); wr(9, 6); wr(10, 3); wr(11, 2);
        wr(0, 1);
        repeat (12) @(negedge clk);
        rd(6, v); chk("R4 pins after matches", v, 5);
        rd(4, v); chk("R5 flags after matches", v, 7);
        chk("R3 disabled channel pin", (v >> 3) & 1, 0);

        // R1 hold while stopped
        wr(0, 0);
        rd(5, c0); repeat (5) @(negedge clk); rd(5, c1);
        chk("R1 counter holds", c1, c0);

        // R6 write-one-to-clear, R7 irq level
        wr(4, 0); rd(4, v); chk("R6 zero write keeps", v, 7);
        wr(4, 2); rd(4, v); chk("R6 one clears", v, 5);
        wr(3, 1); #1; chk("R7 irq ch0", irq, 1);
        wr(4, 1); #1; chk("R7 irq after clear", irq, 0);
        wr(3, 4); #1; chk("R7 irq ch2", irq, 1);
        wr(4, 7); #1; chk("R7 irq no flags", irq, 0);

        // R2 prescale
        wr(0, 5); rd(5, c0); repeat (15) @(negedge clk); rd(5, c1);
        chk("R2 divide by 4", (c1 - c0) & 'hFFFF, 4);
        wr(0, 1); rd(5, c0); repeat (7) @(negedge clk); rd(5, c1);
        chk("R2 divide by 1", (c1 - c0) & 'hFFFF, 8);

        // R9 action none: flag sets, pin0 stays high
        rd(5, v); wr(2, 'hD8); wr(8, (v + 20) & 'hFFFF);
        wait_flag(1, 100, ok); chk("R9 flag still sets", ok, 1);
        rd(6, v); chk("R9 pin unchanged", v & 1, 1);
        wr(4, 15);

        // PWM-style handler on ch1: alternate set/clear
        wr(2, 'hDC);
        rd(5, v); nxt = (v + 10) & 'hFFFF; wr(9, nxt);
        for (int k = 0; k < 6; k++) begin
            wait_flag(2, 400, ok); chk("R5 pwm match", ok, 1);
            rd(6, v); chk("R4 pwm level", (v >> 1) & 1, (k % 2 == 0) ? 1 : 0);
            wr(4, 2);
            wr(2, (k % 2 == 0) ? 'hD8 : 'hDC);
            nxt = (nxt + ((k % 2 == 0) ? 30 : 50)) & 'hFFFF;
            wr(9, nxt);
        end

        // R8 wrap: ch2 at 0xFFFF, ch0 at 0 with clear action
        wr(4, 15); wr(2, 'hDA); wr(8, 0); wr(10, 'hFFFF);
        wait_flag(4, 70000, ok); chk("R8 reached 0xFFFF", ok, 1);
        rd(5, v); chk("R8 wrapped to zero", v, 0);
        rd(4, v); chk("R8 compare zero matched", v & 1, 1);
        rd(6, v); chk("R8 pin0 cleared", v & 1, 0);
        chk("R3 ch3 pin never moved", (v >> 3) & 1, 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end
endmodule